// File: doc/BRIEF.md
# Scoped-Flush Translation Cache

A small fully associative translation cache that holds recently used virtual-to-physical mappings, each tagged with an address-space context and a mapping size (4 KB page, 256 KB segment or 16 MB region). The CPU side presents a virtual page number every cycle and gets a hit flag and the stored 32-bit table entry back in the same cycle. A table walker outside the block installs new mappings through a fill port. Victims are chosen by a round-robin pointer.

A separate control port carries maintenance operations. Their kind is encoded in address bits 11..8. A control write invalidates entries at one of five scopes: page, segment, region, context or everything. A control read with code 4 is a probe. One cycle later it returns the entry word that translates the given address in the current context, or zero when no entry matches. The block never starts a walk on a probe miss.

Top module: `scoped_tlb`

## Requirements
- R1: After reset every entry is invalid, `lkHit` is 0, `rdValid` is 0 and the replacement pointer points at slot 0.
- R2: A lookup hits when a valid entry has context equal to `curCtx` and its stored VA agrees with `lkVa` on bits 31..12 (level 0, 4 KB), 31..18 (level 1, 256 KB) or 31..24 (level 2, 16 MB). A hit returns that entry's word on `lkPte` in the same cycle. A miss returns `lkHit`=0 and `lkPte`=0. When several entries hit, the lowest slot wins.
- R3: A fill writes the slot under the round-robin pointer with `fillVa`, `fillLevel`, `fillPte` and the current context. The pointer then advances by one and wraps from the last slot to 0. A fill with `fillLevel`=3 writes nothing and leaves the pointer unchanged.
- R4: A control write (`ctlEn`=1, `ctlWr`=1) takes its scope from `ctlAddr[11:8]`: 0 page, 1 segment, 2 region, 3 context, 4 everything. Codes 5 to 15 change no entry.
- R5: A page, segment or region flush (codes 0, 1, 2) invalidates only entries of the current context. An entry is removed when its VA agrees with `ctlAddr` at the coarser of the flush granularity and the entry's own level.
- R6: A context flush (code 3) invalidates every entry whose context equals `curCtx` and leaves entries of other contexts intact.
- R7: An entire flush (code 4) invalidates all entries regardless of context.
- R8: A control read (`ctlEn`=1, `ctlWr`=0) sets `rdValid` in the next cycle. `rdData` then holds the word of the entry matching `ctlAddr` under the R2 rule in the current context when the code is 4. It holds 0 on a miss or for any other code.
- R9: Invalidations take effect at the clock edge that ends the flush cycle. A lookup in that same cycle sees the contents from before the flush.
- R10: When a fill and a flush share a cycle, the flush acts on the old contents and the newly filled entry is valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| curCtx | input | CTX_W | Current address-space context |
| lkVa | input | 20 | Lookup virtual address bits 31..12 |
| lkHit | output | 1 | Lookup hit |
| lkPte | output | 32 | Entry word of the hit, zero on a miss |
| fillEn | input | 1 | Install a mapping this cycle |
| fillVa | input | 20 | Virtual address bits 31..12 of the mapping |
| fillLevel | input | 2 | Mapping size: 0 page, 1 segment, 2 region, 3 rejected |
| fillPte | input | 32 | Entry word to store |
| ctlEn | input | 1 | Control operation this cycle |
| ctlWr | input | 1 | 1 flush, 0 probe read |
| ctlAddr | input | 24 | Control address bits 31..8 (code in bits 11..8) |
| rdValid | output | 1 | Probe response present |
| rdData | output | 32 | Probe response word |

## Verification
If an entry is wrongly invalidated, the next lookup of its address misses in the very next cycle. If an entry wrongly survives, a lookup or probe keeps hitting where the reference expects a miss. A compare at the wrong granularity shows as a hit or miss one bit-boundary off. A pointer that drifts only shows later, when a replacement evicts a different mapping than expected. The bench therefore compares every cycle against a behavioural model and walks the pointer through a full wrap so that the eviction becomes visible.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  localparam int VPN_W  = 20;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    LVL_PAGE   = 2'd0,
    LVL_SEG    = 2'd1,
    LVL_REGION = 2'd2,
    LVL_BAD    = 2'd3
  } map_level_e;

  localparam logic [2:0] KIND_PAGE   = 3'd0;
  localparam logic [2:0] KIND_SEG    = 3'd1;
  localparam logic [2:0] KIND_REGION = 3'd2;
  localparam logic [2:0] KIND_CTX    = 3'd3;
  localparam logic [2:0] KIND_ALL    = 3'd4;

  typedef struct packed {
    logic       flushEn;
    logic [2:0] flushKind;
    logic       probeEn;
    logic       probeSel;
    logic       fillEn;
  } tlb_strobe_t;

  function automatic logic vpnAgree(input logic [VPN_W-1:0] a,
                                    input logic [VPN_W-1:0] b,
                                    input logic [1:0]       gran);
    case (gran)
      2'd0:    vpnAgree = (a == b);
      2'd1:    vpnAgree = (a[VPN_W-1:6] == b[VPN_W-1:6]);
      default: vpnAgree = (a[VPN_W-1:12] == b[VPN_W-1:12]);
    endcase
  endfunction

  function automatic logic [1:0] coarser(input logic [1:0] a, input logic [1:0] b);
    coarser = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tlb_ctrl.sv
`timescale 1ns/1ps
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctlEn,
  input  logic                       ctlWr,
  input  logic [3:0]                 ctlCode,
  input  logic                       fillReq,
  input  logic [1:0]                 fillLevel,
  output tlb_strobe_t                strobe,
  output logic [$clog2(ENTRIES)-1:0] fillSlot
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             codeLegal;
  logic [IDX_W-1:0] ptrQ;

  assign codeLegal = (ctlCode <= 4'd4);

  always_comb begin
    strobe.flushEn   = ctlEn && ctlWr && codeLegal;
    strobe.flushKind = ctlCode[2:0];
    strobe.probeEn   = ctlEn && !ctlWr;
    strobe.probeSel  = (ctlCode == 4'd4);
    strobe.fillEn    = fillReq && (fillLevel != LVL_BAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               ptrQ <= '0;
    else if (strobe.fillEn)  ptrQ <= (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
  end

  assign fillSlot = ptrQ;

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(fillReq && (fillLevel != LVL_BAD)) |=> $stable(fillSlot));

  p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillEn && fillSlot == LAST) |=> (fillSlot == '0));

  p_reserved_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEn && ctlWr && ctlCode[3]) |-> !strobe.flushEn);

endmodule

// File: rtl/tlb_datapath.sv
`timescale 1ns/1ps
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tlb_strobe_t                strobe,
  input  logic [$clog2(ENTRIES)-1:0] fillSlot,
  input  logic [CTX_W-1:0]           curCtx,
  input  logic [VPN_W-1:0]           lkVpn,
  input  logic [VPN_W-1:0]           fillVpn,
  input  logic [1:0]                 fillLevel,
  input  logic [WORD_W-1:0]          fillWord,
  input  logic [VPN_W-1:0]           ctlVpn,
  output logic                       lkHit,
  output logic [WORD_W-1:0]          lkWord,
  output logic                       rdValid,
  output logic [WORD_W-1:0]          rdData
);
  logic [ENTRIES-1:0] validQ;
  logic [CTX_W-1:0]   ctxQ  [ENTRIES];
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [1:0]         lvlQ  [ENTRIES];
  logic [WORD_W-1:0]  wordQ [ENTRIES];

  logic [ENTRIES-1:0] ctxEq;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] prMatch;
  logic [ENTRIES-1:0] killVec;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_entry
      assign ctxEq[gi]   = validQ[gi] && (ctxQ[gi] == curCtx);
      assign lkMatch[gi] = ctxEq[gi] && vpnAgree(lkVpn, vpnQ[gi], lvlQ[gi]);
      assign prMatch[gi] = ctxEq[gi] && vpnAgree(ctlVpn, vpnQ[gi], lvlQ[gi]);

      always_comb begin
        case (strobe.flushKind)
          KIND_PAGE, KIND_SEG, KIND_REGION:
            killVec[gi] = ctxEq[gi] &&
                          vpnAgree(ctlVpn, vpnQ[gi], coarser(strobe.flushKind[1:0], lvlQ[gi]));
          KIND_CTX: killVec[gi] = ctxEq[gi];
          KIND_ALL: killVec[gi] = 1'b1;
          default:  killVec[gi] = 1'b0;
        endcase
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[gi] <= 1'b0;
        end else if (strobe.fillEn && fillSlot == gi) begin
          validQ[gi] <= 1'b1;
        end else if (strobe.flushEn && killVec[gi]) begin
          validQ[gi] <= 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ctxQ[gi]  <= '0;
          vpnQ[gi]  <= '0;
          lvlQ[gi]  <= LVL_PAGE;
          wordQ[gi] <= '0;
        end else if (strobe.fillEn && fillSlot == gi) begin
          ctxQ[gi]  <= curCtx;
          vpnQ[gi]  <= fillVpn;
          lvlQ[gi]  <= fillLevel;
          wordQ[gi] <= fillWord;
        end
      end
    end
  endgenerate

  logic              prHit;
  logic [WORD_W-1:0] prWord;

  always_comb begin
    lkHit  = 1'b0;
    lkWord = '0;
    prHit  = 1'b0;
    prWord = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        lkHit  = 1'b1;
        lkWord = wordQ[i];
      end
      if (prMatch[i]) begin
        prHit  = 1'b1;
        prWord = wordQ[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.probeEn;
      rdData  <= (strobe.probeEn && strobe.probeSel && prHit) ? prWord : '0;
    end
  end

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkWord == '0));

  p_all_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flushEn && strobe.flushKind == KIND_ALL && !strobe.fillEn) |=> (validQ == '0));

  p_fill_live_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fillEn |=> validQ[$past(fillSlot)]);

  p_probe_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.probeEn |=> rdValid);

  p_probe_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.probeEn |=> (!rdValid && rdData == '0));

endmodule

// File: rtl/scoped_tlb.sv
`timescale 1ns/1ps
module scoped_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int CTX_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTX_W-1:0]  curCtx,
  input  logic [19:0]       lkVa,
  output logic              lkHit,
  output logic [31:0]       lkPte,
  input  logic              fillEn,
  input  logic [19:0]       fillVa,
  input  logic [1:0]        fillLevel,
  input  logic [31:0]       fillPte,
  input  logic              ctlEn,
  input  logic              ctlWr,
  input  logic [23:0]       ctlAddr,
  output logic              rdValid,
  output logic [31:0]       rdData
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlb_strobe_t      strobe;
  logic [IDX_W-1:0] fillSlot;

  tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlEn     (ctlEn),
    .ctlWr     (ctlWr),
    .ctlCode   (ctlAddr[3:0]),
    .fillReq   (fillEn),
    .fillLevel (fillLevel),
    .strobe    (strobe),
    .fillSlot  (fillSlot)
  );

  tlb_datapath #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fillSlot  (fillSlot),
    .curCtx    (curCtx),
    .lkVpn     (lkVa),
    .fillVpn   (fillVa),
    .fillLevel (fillLevel),
    .fillWord  (fillPte),
    .ctlVpn    (ctlAddr[23:4]),
    .lkHit     (lkHit),
    .lkWord    (lkPte),
    .rdValid   (rdValid),
    .rdData    (rdData)
  );

endmodule

// File: tb/scoped_tlb_bench.sv
`timescale 1ns/1ps
module scoped_tlb_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  curCtx;
  logic [19:0] lkVa;
  logic        lkHit;
  logic [31:0] lkPte;
  logic        fillEn;
  logic [19:0] fillVa;
  logic [1:0]  fillLevel;
  logic [31:0] fillPte;
  logic        ctlEn;
  logic        ctlWr;
  logic [23:0] ctlAddr;
  logic        rdValid;
  logic [31:0] rdData;

  always #2.5 clk = ~clk;

  scoped_tlb u_scoped_tlb (
    .clk(clk), .rstN(rstN), .curCtx(curCtx), .lkVa(lkVa), .lkHit(lkHit), .lkPte(lkPte),
    .fillEn(fillEn), .fillVa(fillVa), .fillLevel(fillLevel), .fillPte(fillPte),
    .ctlEn(ctlEn), .ctlWr(ctlWr), .ctlAddr(ctlAddr), .rdValid(rdValid), .rdData(rdData)
  );

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;
  string curTag = "R1";

  // behavioural reference
  bit          mV   [N];
  int          mCtx [N];
  bit [31:0]   mVa  [N];
  int          mLvl [N];
  bit [31:0]   mPte [N];
  int          mPtr;
  bit          mRdV;
  bit [31:0]   mRd;

  bit          obsHit;
  bit [31:0]   obsPte;
  bit          obsRdV;
  bit [31:0]   obsRd;

  function automatic bit sameArea(bit [31:0] a, bit [31:0] b, int gran);
    int sh;
    sh = (gran == 0) ? 12 : (gran == 1) ? 18 : 24;
    return (a >> sh) == (b >> sh);
  endfunction

  function automatic int findHit(bit [31:0] va);
    for (int i = 0; i < N; i++)
      if (mV[i] && mCtx[i] == int'(curCtx) && sameArea(mVa[i], va, mLvl[i])) return i;
    return -1;
  endfunction

  task automatic step();
    int h;
    int code;
    bit eHit;
    bit [31:0] ePte;
    bit [31:0] cAddr;
    bit nRdV;
    bit [31:0] nRd;
    #2;
    h = findHit({lkVa, 12'h0});
    eHit = (rstN && h >= 0);
    ePte = eHit ? mPte[h] : 32'h0;
    obsHit = lkHit; obsPte = lkPte; obsRdV = rdValid; obsRd = rdData;
    nTests++;
    if (lkHit !== eHit || lkPte !== ePte || rdValid !== mRdV || rdData !== mRd) begin
      nFail++;
      $display("FAIL %s cycle compare: hit=%0b pte=%h rdv=%0b rd=%h expected hit=%0b pte=%h rdv=%0b rd=%h",
               curTag, lkHit, lkPte, rdValid, rdData, eHit, ePte, mRdV, mRd);
    end
    if (!rstN) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
      mPtr = 0; mRdV = 0; mRd = 0;
    end else begin
      cAddr = {ctlAddr, 8'h0};
      code  = int'(ctlAddr[3:0]);
      nRdV  = ctlEn && !ctlWr;
      nRd   = 0;
      if (nRdV && code == 4) begin
        h = findHit(cAddr);
        if (h >= 0) nRd = mPte[h];
      end
      if (ctlEn && ctlWr && code <= 4) begin
        for (int i = 0; i < N; i++) begin
          if (!mV[i]) continue;
          if (code == 4) mV[i] = 0;
          else if (mCtx[i] == int'(curCtx)) begin
            if (code == 3) mV[i] = 0;
            else if (sameArea(mVa[i], cAddr, (code > mLvl[i]) ? code : mLvl[i])) mV[i] = 0;
          end
        end
      end
      if (fillEn && fillLevel != 2'd3) begin
        mV[mPtr] = 1; mCtx[mPtr] = int'(curCtx); mVa[mPtr] = {fillVa, 12'h0};
        mLvl[mPtr] = int'(fillLevel); mPte[mPtr] = fillPte;
        mPtr = (mPtr + 1) % N;
      end
      mRdV = nRdV; mRd = nRd;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    fillEn = 0; ctlEn = 0; ctlWr = 0; ctlAddr = 0; fillVa = 0; fillLevel = 0; fillPte = 0;
  endtask

  task automatic doFill(bit [31:0] va, bit [1:0] lvl, bit [31:0] pte);
    fillEn = 1; fillVa = va[31:12]; fillLevel = lvl; fillPte = pte;
    step();
    idle();
  endtask

  task automatic doCtl(bit wr, bit [31:0] addr);
    ctlEn = 1; ctlWr = wr; ctlAddr = addr[31:8];
    step();
    idle();
  endtask

  task automatic expectLook(bit [31:0] va, bit eh, bit [31:0] ep, string tag);
    lkVa = va[31:12];
    step();
    nTests++;
    if (obsHit !== eh || obsPte !== ep) begin
      nFail++;
      $display("FAIL %s lookup %h: hit=%0b pte=%h expected hit=%0b pte=%h", tag, va, obsHit, obsPte, eh, ep);
    end
  endtask

  task automatic expectProbe(bit [31:0] addr, bit [31:0] ed, string tag);
    doCtl(0, addr);
    step();
    nTests++;
    if (obsRdV !== 1'b1 || obsRd !== ed) begin
      nFail++;
      $display("FAIL %s probe %h: rdv=%0b rd=%h expected rdv=1 rd=%h", tag, addr, obsRdV, obsRd, ed);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not finish, got running expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    bit [31:0] pool [6];
    pool[0] = 32'h0040_1000; pool[1] = 32'h0040_2000; pool[2] = 32'h0083_F000;
    pool[3] = 32'h0080_0000; pool[4] = 32'h0300_0000; pool[5] = 32'h03FF_F000;
    rstN = 0; curCtx = 8'd1; lkVa = 0; idle();
    mPtr = 0; mRdV = 0; mRd = 0;
    for (int i = 0; i < N; i++) mV[i] = 0;
    @(negedge clk);
    curTag = "R1";
    repeat (3) step();
    rstN = 1;
    expectLook(32'h0040_1000, 0, 0, "R1");
    nTests++;
    if (obsRdV !== 1'b0) begin nFail++; $display("FAIL R1 rdValid=%0b expected 0", obsRdV); end

    curTag = "R3";
    doFill(32'h0040_1000, 2'd0, 32'hA000_00A2);
    doFill(32'h0080_0000, 2'd1, 32'hB000_00B2);
    doFill(32'h0300_0000, 2'd2, 32'hC000_00C2);
    curTag = "R2";
    expectLook(32'h0040_1ABC, 1, 32'hA000_00A2, "R2");
    expectLook(32'h0040_2000, 0, 0, "R2");
    expectLook(32'h0083_FFFF, 1, 32'hB000_00B2, "R2");
    expectLook(32'h0084_0000, 0, 0, "R2");
    expectLook(32'h03FF_FFFF, 1, 32'hC000_00C2, "R2");
    expectLook(32'h0400_0000, 0, 0, "R2");

    curTag = "R8";
    expectProbe(32'h0300_0400, 32'hC000_00C2, "R8");
    expectProbe(32'h0300_0000, 32'h0, "R8");
    expectProbe(32'h0500_0400, 32'h0, "R8");

    curTag = "R4";
    doCtl(1, 32'h0040_1500);
    expectLook(32'h0040_1000, 1, 32'hA000_00A2, "R4");

    curTag = "R5";
    doCtl(1, 32'h0083_0000);
    expectLook(32'h0080_0000, 0, 0, "R5");
    expectLook(32'h0040_1000, 1, 32'hA000_00A2, "R5");
    curCtx = 8'd2;
    doFill(32'h0040_1000, 2'd0, 32'hD000_00D2);
    curCtx = 8'd1;
    doCtl(1, 32'h0000_0200);
    expectLook(32'h0040_1000, 0, 0, "R5");
    expectLook(32'h0300_0000, 1, 32'hC000_00C2, "R5");
    curCtx = 8'd2;
    expectLook(32'h0040_1000, 1, 32'hD000_00D2, "R5");

    curTag = "R6";
    curCtx = 8'd1;
    doCtl(1, 32'h0000_0300);
    expectLook(32'h0300_0000, 0, 0, "R6");
    curCtx = 8'd2;
    expectLook(32'h0040_1000, 1, 32'hD000_00D2, "R6");

    curTag = "R9";
    lkVa = 20'h00401; ctlEn = 1; ctlWr = 1; ctlAddr = 24'h000004;
    step();
    idle();
    nTests++;
    if (obsHit !== 1'b1 || obsPte !== 32'hD000_00D2) begin
      nFail++; $display("FAIL R9 same-cycle lookup: hit=%0b pte=%h expected hit=1 pte=d00000d2", obsHit, obsPte);
    end
    curTag = "R7";
    expectLook(32'h0040_1000, 0, 0, "R7");

    curTag = "R10";
    fillEn = 1; fillVa = 20'h01000; fillLevel = 2'd2; fillPte = 32'hE000_00E2;
    ctlEn = 1; ctlWr = 1; ctlAddr = 24'h000004;
    step();
    idle();
    expectLook(32'h0100_0000, 1, 32'hE000_00E2, "R10");

    curTag = "R3";
    doFill(32'h0200_0000, 2'd3, 32'hBAD0_0002);
    expectLook(32'h0200_0000, 0, 0, "R3");
    for (int i = 0; i < 16; i++) doFill(32'h1000_0000 + i * 32'h1000, 2'd0, 32'hF000_0002 + i * 32'h100);
    expectLook(32'h0100_0000, 0, 0, "R3");
    expectLook(32'h1000_0000, 1, 32'hF000_0002, "R3");
    doFill(32'h2000_0000, 2'd0, 32'h9000_0002);
    expectLook(32'h1000_0000, 0, 0, "R3");
    expectLook(32'h1000_1000, 1, 32'hF000_0102, "R3");

    curTag = "R2/R5/R8 mixed";
    for (int c = 0; c < 3000; c++) begin
      int r;
      bit [31:0] a;
      r = int'($urandom_range(0, 9));
      a = pool[$urandom_range(0, 5)] | ($urandom & 32'h0000_0FFF);
      lkVa = pool[$urandom_range(0, 5)] >> 12;
      if (($urandom & 32'h1F) == 0) curCtx = 8'($urandom_range(0, 2));
      if (r < 3) begin
        fillEn = 1; fillVa = a[31:12]; fillLevel = 2'($urandom_range(0, 3));
        fillPte = $urandom;
      end
      if (r >= 2 && r < 7) begin
        ctlEn = 1; ctlWr = ($urandom & 1) == 1;
        ctlAddr = {a[31:12], 4'($urandom_range(0, 6))};
      end
      step();
      idle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule